// File: doc/BRIEF.md
# CAN Frame Acceptance Filter

This block decides whether a frame that a CAN receiver has just taken from the bus should be kept. It takes the frame's identifier, its extended-format and remote-request flags, its data length code and its first two data bytes. These are captured on a frame strobe. One cycle later it reports accept or reject.

The decision is made against eight configuration bytes on the `acc_bytes` port. Byte k sits at bits [8k+7:8k]. Bytes 0 to 3 are acceptance code and bytes 4 to 7 are acceptance mask. A mask bit of 1 makes the matching code bit a don't-care.

Three filter arrangements are selected by `enh_mode` and `dual_mode`:
- One wide filter.
- Two narrower filters, where either one may accept the frame.
- A legacy arrangement that compares a single code byte with a single mask byte.

For standard frames, the single and dual arrangements can also inspect payload bytes.

Top module: `can_accept_filter`

## Requirements
- R1: A bit is compared only where its mask bit is 0. When all four mask bytes (4..7) are 0xFF and `enh_mode`=1, every frame is accepted in both single and dual arrangements.
- R2: Single filter (`enh_mode`=1, `dual_mode`=0) with an extended frame: the code is laid out as follows, and mask bytes 4..7 use the same layout.
  - id[28:21] is compared with byte 0.
  - id[20:13] is compared with byte 1.
  - id[12:5] is compared with byte 2.
  - id[4:0] is compared with byte 3 bits 7..3.
  - The remote flag is compared with byte 3 bit 2.
- R3: Single filter with a standard frame: id[10:3] is compared with byte 0, id[2:0] with byte 1 bits 7..5, and the remote flag with byte 1 bit 4. Mask bytes 4 and 5 cover these bits in the same positions.
- R4: Single filter with a standard frame whose identifier matches: a remote frame, or a frame with DLC 0, is accepted whatever its data bytes hold.
- R5: Single filter with a standard data frame whose identifier matches: data byte 0 must match byte 2 under mask byte 6. When DLC is 2 or more, data byte 1 must also match byte 3 under mask byte 7. When DLC is 1, data byte 1 is ignored.
- R6: Dual filter (`enh_mode`=1, `dual_mode`=1) with an extended frame: only id[28:13] is compared. The first filter uses bytes 0..1 under masks 4..5 and the second uses bytes 2..3 under masks 6..7. The frame is accepted if either filter matches, and the remote flag and id[12:0] are ignored.
- R7: Dual filter, standard frame, first filter:
  - The identifier and remote flag are compared as in R3, using bytes 0..1 and masks 4..5.
  - Data byte 0 is compared with {byte1[3:0], byte3[3:0]} under the mask {mask5[3:0], mask7[3:0]}.
  - With DLC 0 the data comparison passes.
- R8: Dual filter, standard frame, second filter: id[10:3] is compared with byte 2, id[2:0] with byte 3 bits 7..5, and the remote flag with byte 3 bit 4, under masks 6 and 7. No data byte is compared. The frame is accepted if either filter passes.
- R9: Legacy arrangement (`enh_mode`=0): id[10:3] is compared with byte 0 under mask byte 4. The remote flag, DLC and data bytes are ignored, and extended frames are always rejected.
- R10: `dec_valid` is high in exactly the cycle after `frm_valid` was high. `accept` then reflects the frame captured on that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame fields are valid; capture them |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Identifier; standard frames use bits 10..0 |
| frm_dlc | input | 4 | Data length code |
| frm_d0 | input | 8 | First data byte |
| frm_d1 | input | 8 | Second data byte |
| enh_mode | input | 1 | 1 selects the eight-byte filter, 0 the legacy one |
| dual_mode | input | 1 | With `enh_mode`=1, 1 selects two filters |
| acc_bytes | input | 64 | Code bytes 0..3 and mask bytes 4..7 |
| dec_valid | output | 1 | Decision is valid this cycle |
| accept | output | 1 | Frame is accepted |

## Verification
The assertions assume that `acc_bytes`, `enh_mode` and `dual_mode` stay constant from the capture strobe through the decision cycle. In the controller, this configuration changes only while reception is halted. The bench therefore applies a new configuration only together with a new frame strobe, and holds it until the decision has been sampled. Random configurations draw mask bytes with mostly set bits, so that matches and rejects both occur often. Directed frames cover the early-accept and DLC boundary rules.

// File: rtl/can_accept_filter.sv
module can_accept_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid,
  input  logic        frm_ext,
  input  logic        frm_rtr,
  input  logic [28:0] frm_id,
  input  logic [3:0]  frm_dlc,
  input  logic [7:0]  frm_d0,
  input  logic [7:0]  frm_d1,
  input  logic        enh_mode,
  input  logic        dual_mode,
  input  logic [63:0] acc_bytes,
  output logic        dec_valid,
  output logic        accept
);

  logic        ext_q, rtr_q;
  logic [28:0] id_q;
  logic [3:0]  dlc_q;
  logic [7:0]  d0_q, d1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      ext_q     <= 1'b0;
      rtr_q     <= 1'b0;
      id_q      <= '0;
      dlc_q     <= '0;
      d0_q      <= '0;
      d1_q      <= '0;
    end else begin
      dec_valid <= frm_valid;
      if (frm_valid) begin
        ext_q <= frm_ext;
        rtr_q <= frm_rtr;
        id_q  <= frm_id;
        dlc_q <= frm_dlc;
        d0_q  <= frm_d0;
        d1_q  <= frm_d1;
      end
    end
  end

  wire [7:0] c0 = acc_bytes[7:0];
  wire [7:0] c1 = acc_bytes[15:8];
  wire [7:0] c2 = acc_bytes[23:16];
  wire [7:0] c3 = acc_bytes[31:24];
  wire [7:0] m4 = acc_bytes[39:32];
  wire [7:0] m5 = acc_bytes[47:40];
  wire [7:0] m6 = acc_bytes[55:48];
  wire [7:0] m7 = acc_bytes[63:56];

  function automatic logic hit(input logic [31:0] a, input logic [31:0] c, input logic [31:0] m);
    return ((a ^ c) & ~m) == 32'd0;
  endfunction

  wire [11:0] std_key = {id_q[10:0], rtr_q};

  wire sgl_ext = hit(32'({id_q, rtr_q}), 32'({c0, c1, c2, c3[7:2]}), 32'({m4, m5, m6, m7[7:2]}));
  wire sgl_id  = hit(32'(std_key), 32'({c0, c1[7:4]}), 32'({m4, m5[7:4]}));
  wire d0_hit  = hit(32'(d0_q), 32'(c2), 32'(m6));
  wire d1_hit  = hit(32'(d1_q), 32'(c3), 32'(m7));
  wire sgl_std = sgl_id && (rtr_q || dlc_q == 4'd0 || (d0_hit && (dlc_q == 4'd1 || d1_hit)));

  wire dul_ext = hit(32'(id_q[28:13]), 32'({c0, c1}), 32'({m4, m5}))
              || hit(32'(id_q[28:13]), 32'({c2, c3}), 32'({m6, m7}));
  wire f1_dat  = dlc_q == 4'd0 || hit(32'(d0_q), 32'({c1[3:0], c3[3:0]}), 32'({m5[3:0], m7[3:0]}));
  wire f1_std  = sgl_id && f1_dat;
  wire f2_std  = hit(32'(std_key), 32'({c2, c3[7:4]}), 32'({m6, m7[7:4]}));
  wire dul_std = f1_std || f2_std;

  wire legacy  = !ext_q && hit(32'(id_q[10:3]), 32'(c0), 32'(m4));

  always_comb begin
    if (!enh_mode)      accept = legacy;
    else if (dual_mode) accept = ext_q ? dul_ext : dul_std;
    else                accept = ext_q ? sgl_ext : sgl_std;
  end

  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> dec_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !dec_valid);

  p_legacy_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !enh_mode && $past(frm_ext) |-> !accept);

  p_all_dont_care_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && enh_mode && acc_bytes[63:32] == 32'hFFFF_FFFF |-> accept);

  p_empty_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && enh_mode && !dual_mode && $past(!frm_ext && frm_dlc == 4'd0)
      && acc_bytes[47:32] == 16'hFFFF |-> accept);

endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [7:0]  frm_d0 = '0, frm_d1 = '0;
  logic        enh_mode = 1'b0, dual_mode = 1'b0;
  logic [63:0] acc_bytes = '0;
  logic        dec_valid, accept;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  can_accept_filter uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] bt(input logic [63:0] a, input int k);
    return a[8*k +: 8];
  endfunction

  function automatic logic eqm(input logic [31:0] v, input logic [31:0] c, input logic [31:0] m);
    for (int i = 0; i < 32; i++)
      if (!m[i] && v[i] != c[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic ref_acc(input logic en, input logic du, input logic [63:0] a,
                                   input logic ex, input logic rt, input logic [28:0] id,
                                   input logic [3:0] dl, input logic [7:0] x0, input logic [7:0] x1);
    logic ida, idb, dat;
    if (!en) return !ex && eqm({24'd0, id[10:3]}, {24'd0, bt(a,0)}, {24'd0, bt(a,4)});
    if (ex && !du)
      return eqm({3'd0, id[28:21], id[20:13], id[12:5], id[4:0]},
                 {3'd0, bt(a,0), bt(a,1), bt(a,2), bt(a,3)[7:3]},
                 {3'd0, bt(a,4), bt(a,5), bt(a,6), bt(a,7)[7:3]})
          && (bt(a,7)[2] || rt == bt(a,3)[2]);
    if (ex)
      return eqm({16'd0, id[28:13]}, {16'd0, bt(a,0), bt(a,1)}, {16'd0, bt(a,4), bt(a,5)})
          || eqm({16'd0, id[28:13]}, {16'd0, bt(a,2), bt(a,3)}, {16'd0, bt(a,6), bt(a,7)});
    ida = eqm({20'd0, id[10:0], rt}, {20'd0, bt(a,0), bt(a,1)[7:4]}, {20'd0, bt(a,4), bt(a,5)[7:4]});
    if (!du) begin
      if (!ida) return 1'b0;
      if (rt || dl == 0) return 1'b1;
      if (!eqm({24'd0, x0}, {24'd0, bt(a,2)}, {24'd0, bt(a,6)})) return 1'b0;
      if (dl == 1) return 1'b1;
      return eqm({24'd0, x1}, {24'd0, bt(a,3)}, {24'd0, bt(a,7)});
    end
    dat = (dl == 0) || eqm({24'd0, x0}, {24'd0, bt(a,1)[3:0], bt(a,3)[3:0]},
                           {24'd0, bt(a,5)[3:0], bt(a,7)[3:0]});
    idb = eqm({20'd0, id[10:0], rt}, {20'd0, bt(a,2), bt(a,3)[7:4]}, {20'd0, bt(a,6), bt(a,7)[7:4]});
    return (ida && dat) || idb;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic en, input logic du, input logic [63:0] a,
                      input logic ex, input logic rt, input logic [28:0] id,
                      input logic [3:0] dl, input logic [7:0] x0, input logic [7:0] x1);
    enh_mode = en; dual_mode = du; acc_bytes = a;
    frm_ext = ex; frm_rtr = rt; frm_id = id; frm_dlc = dl; frm_d0 = x0; frm_d1 = x1;
    frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    frm_id = ~id; frm_d0 = ~x0; frm_d1 = ~x1; frm_ext = ~ex; frm_rtr = ~rt;
    check({req, " R10 valid"}, dec_valid, 1'b1);
    check(req, accept, ref_acc(en, du, a, ex, rt, id, dl, x0, x1));
    @(negedge clk);
    check({req, " R10 idle"}, dec_valid, 1'b0);
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    logic [63:0] a;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("reset R10", dec_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("idle after reset R10", dec_valid, 1'b0);

    // R9: legacy, byte0 code 0xA5 mask 0x00 over id[10:3]
    a = 64'h0000_0000_0000_00A5;
    send("R9 std match", 1'b0, 1'b0, a, 1'b0, 1'b1, {18'd0, 8'hA5, 3'b111}, 4'd8, 8'h00, 8'h00);
    send("R9 ext reject", 1'b0, 1'b0, a, 1'b1, 1'b0, {18'd0, 8'hA5, 3'b000}, 4'd0, 8'h00, 8'h00);
    send("R9 std mismatch", 1'b0, 1'b0, a, 1'b0, 1'b0, {18'd0, 8'hA4, 3'b000}, 4'd0, 8'h00, 8'h00);
    // R1: all masks set
    send("R1 single ext", 1'b1, 1'b0, 64'hFFFF_FFFF_1234_5678, 1'b1, 1'b1, 29'h1ABCDEF0, 4'd3, 8'h11, 8'h22);
    send("R1 dual std", 1'b1, 1'b1, 64'hFFFF_FFFF_1234_5678, 1'b0, 1'b0, 29'h7FF, 4'd8, 8'h11, 8'h22);
    // R3/R4/R5: code id 0x123 data frame, payload 0x5A 0x3C, masks zero
    a = {32'h0000_0000, 8'h3C, 8'h5A, 8'h60, 8'h24};
    send("R4 remote early", 1'b1, 1'b0, {a[63:48], 8'h10, a[39:0]}, 1'b0, 1'b1, 29'h123, 4'd2, 8'h00, 8'h00);
    send("R4 dlc0 early", 1'b1, 1'b0, a, 1'b0, 1'b0, 29'h123, 4'd0, 8'hFF, 8'hFF);
    send("R5 dlc1 ignores d1", 1'b1, 1'b0, a, 1'b0, 1'b0, 29'h123, 4'd1, 8'h5A, 8'h00);
    send("R5 dlc2 d1 mismatch", 1'b1, 1'b0, a, 1'b0, 1'b0, 29'h123, 4'd2, 8'h5A, 8'h00);
    send("R5 dlc2 match", 1'b1, 1'b0, a, 1'b0, 1'b0, 29'h123, 4'd2, 8'h5A, 8'h3C);
    send("R3 id mismatch", 1'b1, 1'b0, a, 1'b0, 1'b0, 29'h122, 4'd0, 8'h00, 8'h00);
    // R2: single extended exact
    send("R2 ext match", 1'b1, 1'b0, {32'h0, 8'h6C, 8'h5E, 8'h4F, 8'h2A}, 1'b1, 1'b1, {8'h2A, 8'h4F, 8'h5E, 5'b01101}, 4'd0, 8'h0, 8'h0);
    send("R2 ext rtr mismatch", 1'b1, 1'b0, {32'h0, 8'h6C, 8'h5E, 8'h4F, 8'h2A}, 1'b1, 1'b0, {8'h2A, 8'h4F, 8'h5E, 5'b01101}, 4'd0, 8'h0, 8'h0);
    // R6: dual ext, second filter match, low bits differ
    send("R6 second filter", 1'b1, 1'b1, {32'h0, 8'hCD, 8'hAB, 8'h00, 8'h11}, 1'b1, 1'b1, {8'hAB, 8'hCD, 13'h1FFF}, 4'd0, 8'h0, 8'h0);
    send("R6 no filter", 1'b1, 1'b1, {32'h0, 8'hCD, 8'hAB, 8'h00, 8'h11}, 1'b1, 1'b0, {8'hAB, 8'hCC, 13'h0}, 4'd0, 8'h0, 8'h0);
    // R7/R8: filter1 id 0x123, nibbles give expected data 0x95; filter2 id 0x7FF
    a = {32'h0000_0000, 8'hE5, 8'hFF, 8'h69, 8'h24};
    send("R7 data match", 1'b1, 1'b1, a, 1'b0, 1'b0, 29'h123, 4'd1, 8'h95, 8'h00);
    send("R7 data mismatch", 1'b1, 1'b1, a, 1'b0, 1'b0, 29'h123, 4'd1, 8'h96, 8'h00);
    send("R7 dlc0 passes", 1'b1, 1'b1, a, 1'b0, 1'b0, 29'h123, 4'd0, 8'h96, 8'h00);
    send("R8 second filter", 1'b1, 1'b1, a, 1'b0, 1'b0, 29'h7FF, 4'd4, 8'h00, 8'h00);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] r;
      r[31:0]  = $urandom;
      r[63:32] = $urandom | $urandom | $urandom;
      send("R1 random", 1'($urandom), 1'($urandom), r, 1'($urandom), 1'($urandom),
           29'($urandom), 4'($urandom_range(0, 9)), 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule